// File: doc/BRIEF.md
# Interrupt Status and Abort Register

This block is the one host-visible status and control byte of a scripted bus controller. It is the only register the host may touch while the controller core is running, and touching it never disturbs that run. Reads are purely combinational and have no side effects. Writes change only the host-owned control bits.

Two interrupt sources feed the block: the bus side and the DMA side. Each source has a small queue of pending events, so an event that arrives while an earlier one is being serviced is stacked behind it and not lost. A pending bit drops when the matching per-source status read is acknowledged. If more events of that kind are still queued, the bit returns one cycle later. A third kind of interrupt is the on-the-fly flag, which the host clears by writing 1 to it.

The host can also issue two commands:
- **Abort.** The core receives a one-cycle abort strobe. For as long as the abort bit stays set, the block keeps posting DMA interrupts marked as aborted. The host stops this by writing 00h before it reads the DMA status.
- **Software reset.** A self-clearing command that returns every bit and every queued event to its reset value.

The interrupt line is the OR of the three pending kinds, gated by an enable input.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset `rd_data_o` is 00h, and `irq_o`, `abort_req_o`, `swreset_o`, `scsi_ovf_o`, `dma_ovf_o` and `abort_cause_o` are 0.
- R2: The read bits are, MSB to LSB:
  - bit 7: abort
  - bit 6: software reset
  - bit 5: signal
  - bit 4: semaphore
  - bit 3: connected (mirrors `connected_i`)
  - bit 2: on-the-fly interrupt
  - bit 1: bus interrupt pending
  - bit 0: DMA interrupt pending

  A write loads bits 7, 5 and 4 from the written byte, and bits 5 and 4 drive `sig_o` and `sem_o`.
- R3: An event input high at a clock edge makes its pending bit read 1 after that edge.
- R4: An acknowledge pops one queued event of its source. After the pop edge the pending bit reads 0 for one cycle. It then reads 1 again if an event is still queued, and stays 0 otherwise.
- R5: Each source queues up to `STACK_DEPTH` events. An event that arrives while the queue is full and not being popped is dropped, and it sets that source's sticky overflow output.
- R6: Writing a byte with bit 7 set makes bit 7 read 1 and pulses `abort_req_o` high for exactly the first cycle. On the next edge a DMA event is queued with `abort_cause_o` = 1.
- R7: While bit 7 stays set and the DMA queue is empty, a new aborted DMA event is queued on each edge. After 00h is written, acknowledging the queued event leaves bit 0 at 0.
- R8: Writing a byte with bit 6 set clears every other bit, both queues and both overflow flags on that edge. Bit 6 and `swreset_o` then read 1 for exactly one cycle and return to 0.
- R9: `irq_o` is 1 exactly when `irq_en_i` is 1 and any of bits 2, 1 or 0 is 1.
- R10: `fly_evt_i` sets bit 2. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged.
- R11: Host writes of bits 5 and 4 leave the pending bits and queued events unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_data_o | output | 8 | Register read value |
| scsi_evt_i | input | 1 | Bus-side interrupt event |
| dma_evt_i | input | 1 | DMA-side interrupt event |
| fly_evt_i | input | 1 | On-the-fly interrupt event |
| connected_i | input | 1 | Bus connected status |
| scsi_ack_i | input | 1 | Bus status read acknowledge |
| dma_ack_i | input | 1 | DMA status read acknowledge |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_o | output | 1 | Combined interrupt |
| abort_req_o | output | 1 | One-cycle abort strobe to the core |
| swreset_o | output | 1 | One-cycle software reset to the core |
| sig_o | output | 1 | Signal bit to the core |
| sem_o | output | 1 | Semaphore bit |
| abort_cause_o | output | 1 | Head DMA event is an aborted one |
| scsi_ovf_o | output | 1 | Sticky bus queue overflow |
| dma_ovf_o | output | 1 | Sticky DMA queue overflow |

## Verification
The bench builds the block with `STACK_DEPTH` = 2. With that depth, three back-to-back DMA events are enough to fill a queue and then overflow it. The same depth lets a two-deep bus queue show the drop and return of the pending bit between two acknowledges. Because the depth is small, the overflow flag can be checked both for surviving a full drain and for being cleared by the software reset.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int REG_W = 8;
  // bit positions are decoded by host software
  localparam int B_ABORT = 7;
  localparam int B_SWRST = 6;
  localparam int B_SIG   = 5;
  localparam int B_SEM   = 4;
  localparam int B_CONN  = 3;
  localparam int B_FLY   = 2;
  localparam int B_SCSI  = 1;
  localparam int B_DMA   = 0;

  localparam int NUM_SRC  = 2;
  localparam int SRC_DMA  = 0;
  localparam int SRC_SCSI = 1;
endpackage

// File: rtl/irq_evt_stack.sv
module irq_evt_stack #(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              pend_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] head_o,
  output logic              ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] q_mem [DEPTH];
  logic [CW-1:0]     count_q;
  logic              popped_q;
  logic              ovf_q;
  logic              pop_ok, push_ok;
  logic [IW-1:0]     wr_idx;

  assign pop_ok  = pop_i && (count_q != '0);
  assign push_ok = push_i && ((count_q < CW'(DEPTH)) || pop_ok);
  assign wr_idx  = IW'(count_q - CW'(pop_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      popped_q <= 1'b0;
      ovf_q    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) q_mem[i] <= '0;
    end else if (clr_i) begin
      count_q  <= '0;
      popped_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      popped_q <= pop_ok;
      if (push_i && !push_ok) ovf_q <= 1'b1;
      if (pop_ok)
        for (int i = 0; i < DEPTH - 1; i++) q_mem[i] <= q_mem[i+1];
      if (push_ok) q_mem[wr_idx] <= data_i;
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // pending drops for one cycle after a pop so a stacked event re-asserts
  assign pend_o  = (count_q != '0) && !popped_q;
  assign empty_o = (count_q == '0);
  assign head_o  = q_mem[0];
  assign ovf_o   = ovf_q;

  assert_push_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |=> (count_q != '0));

  assert_pop_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clr_i && count_q != '0) |=> (count_q == $past(count_q) - CW'(1)));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(push_i && !pop_i && !clr_i && count_q == CW'(DEPTH)));

  assert_depth_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/irq_abort_seq.sv
module irq_abort_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wr_abort_i,
  input  logic dma_empty_i,
  output logic abort_o,
  output logic req_o,
  output logic inject_o
);
  logic abort_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      prev_q <= abort_q;
      if (clr_i)     abort_q <= 1'b0;
      else if (wr_i) abort_q <= wr_abort_i;
    end
  end

  assign abort_o  = abort_q;
  assign req_o    = abort_q && !prev_q;
  // keeps posting aborted DMA events until host clears the bit
  assign inject_o = abort_q && dma_empty_i && !clr_i;

  assert_req_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  assert_req_follows_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(wr_i && wr_abort_i && !clr_i));
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_status_pkg::*;
#(
  parameter int STACK_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             scsi_evt_i,
  input  logic             dma_evt_i,
  input  logic             fly_evt_i,
  input  logic             connected_i,
  input  logic             scsi_ack_i,
  input  logic             dma_ack_i,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             abort_req_o,
  output logic             swreset_o,
  output logic             sig_o,
  output logic             sem_o,
  output logic             abort_cause_o,
  output logic             scsi_ovf_o,
  output logic             dma_ovf_o
);
  logic swrst_q, sig_q, sem_q, fly_q;
  logic soft_clr, clr;
  logic abort_bit, abort_inject;

  logic [NUM_SRC-1:0] push, pop, tag_in, pend, empty, head, ovf;
  logic unused_scsi_head;

  assign soft_clr = wr_en_i && wr_data_i[B_SWRST];
  assign clr      = soft_clr || swrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swrst_q <= 1'b0;
      sig_q   <= 1'b0;
      sem_q   <= 1'b0;
      fly_q   <= 1'b0;
    end else begin
      swrst_q <= soft_clr;
      if (clr) begin
        sig_q <= 1'b0;
        sem_q <= 1'b0;
        fly_q <= 1'b0;
      end else begin
        if (wr_en_i) begin
          sig_q <= wr_data_i[B_SIG];
          sem_q <= wr_data_i[B_SEM];
        end
        if (fly_evt_i)                         fly_q <= 1'b1;
        else if (wr_en_i && wr_data_i[B_FLY])  fly_q <= 1'b0;
      end
    end
  end

  irq_abort_seq u_abort (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .wr_i        (wr_en_i),
    .wr_abort_i  (wr_data_i[B_ABORT]),
    .dma_empty_i (empty[SRC_DMA]),
    .abort_o     (abort_bit),
    .req_o       (abort_req_o),
    .inject_o    (abort_inject)
  );

  always_comb begin
    push[SRC_DMA]    = dma_evt_i || abort_inject;
    tag_in[SRC_DMA]  = abort_inject;
    pop[SRC_DMA]     = dma_ack_i;
    push[SRC_SCSI]   = scsi_evt_i;
    tag_in[SRC_SCSI] = 1'b0;
    pop[SRC_SCSI]    = scsi_ack_i;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irq_evt_stack #(.DEPTH(STACK_DEPTH), .DATA_W(1)) u_stack (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .push_i  (push[s]),
      .data_i  (tag_in[s]),
      .pop_i   (pop[s]),
      .pend_o  (pend[s]),
      .empty_o (empty[s]),
      .head_o  (head[s]),
      .ovf_o   (ovf[s])
    );
  end

  assign unused_scsi_head = head[SRC_SCSI];

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[B_ABORT] = abort_bit;
    rd_data_o[B_SWRST] = swrst_q;
    rd_data_o[B_SIG]   = sig_q;
    rd_data_o[B_SEM]   = sem_q;
    rd_data_o[B_CONN]  = connected_i;
    rd_data_o[B_FLY]   = fly_q;
    rd_data_o[B_SCSI]  = pend[SRC_SCSI];
    rd_data_o[B_DMA]   = pend[SRC_DMA];
  end

  assign irq_o         = irq_en_i && (fly_q || pend[SRC_SCSI] || pend[SRC_DMA]);
  assign swreset_o     = swrst_q;
  assign sig_o         = sig_q;
  assign sem_o         = sem_q;
  assign abort_cause_o = !empty[SRC_DMA] && head[SRC_DMA];
  assign scsi_ovf_o    = ovf[SRC_SCSI];
  assign dma_ovf_o     = ovf[SRC_DMA];

  assert_abort_repeat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_bit && empty[SRC_DMA] && !clr) |=> abort_cause_o);

  assert_srst_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> !swrst_q);

  assert_srst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |-> (!abort_bit && empty == '0 - '0 + {NUM_SRC{1'b1}} && ovf == '0));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && rd_data_o[B_FLY:B_DMA] != '0));

  assert_fly_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fly_evt_i && !clr) |=> fly_q);
endmodule

// File: tb/sim_irq_status_ctl.sv
module sim_irq_status_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic scsi_evt_i = 0, dma_evt_i = 0, fly_evt_i = 0, connected_i = 0;
  logic scsi_ack_i = 0, dma_ack_i = 0, irq_en_i = 0;
  logic irq_o, abort_req_o, swreset_o, sig_o, sem_o, abort_cause_o, scsi_ovf_o, dma_ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_status_ctl #(.STACK_DEPTH(2)) u0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .scsi_evt_i, .dma_evt_i, .fly_evt_i, .connected_i,
    .scsi_ack_i, .dma_ack_i, .irq_en_i, .irq_o, .abort_req_o,
    .swreset_o, .sig_o, .sem_o, .abort_cause_o, .scsi_ovf_o, .dma_ovf_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    check("R1 rd", rd_data_o, 8'h00);
    check("R1 outs", {irq_o, abort_req_o, swreset_o, scsi_ovf_o, dma_ovf_o, abort_cause_o}, 8'h00);
  endtask

  task automatic t_bits();
    connected_i = 1'b1; step();
    check("R2 connected bit3", rd_data_o, 8'h08);
    wr(8'h30);
    check("R2 sig/sem bits", rd_data_o, 8'h38);
    check("R2 sig_o/sem_o", {sig_o, sem_o}, 8'h03);
    connected_i = 1'b0;
    wr(8'h00);
    check("R2 cleared", rd_data_o, 8'h00);
  endtask

  task automatic t_scsi_stack();
    irq_en_i = 1'b1;
    scsi_evt_i = 1'b1; step(); step(); scsi_evt_i = 1'b0;
    check("R3 scsi pending", rd_data_o, 8'h02);
    check("R9 irq on scsi", irq_o, 1);
    wr(8'h10);
    check("R11 sem write keeps pending", rd_data_o, 8'h12);
    wr(8'h00);
    scsi_ack_i = 1'b1; step(); scsi_ack_i = 1'b0;
    check("R4 drop after pop", rd_data_o, 8'h00);
    check("R9 irq low in gap", irq_o, 0);
    step();
    check("R4 stacked reasserts", rd_data_o, 8'h02);
    scsi_ack_i = 1'b1; step(); scsi_ack_i = 1'b0;
    check("R4 second pop", rd_data_o, 8'h00);
    step();
    check("R4 queue empty", rd_data_o, 8'h00);
  endtask

  task automatic t_irq_mask();
    scsi_evt_i = 1'b1; step(); scsi_evt_i = 1'b0;
    irq_en_i = 1'b0; step();
    check("R9 masked irq", irq_o, 0);
    check("R9 masked still pending", rd_data_o, 8'h02);
    irq_en_i = 1'b1; step();
    check("R9 enabled irq", irq_o, 1);
    scsi_ack_i = 1'b1; step(); scsi_ack_i = 1'b0; step();
    check("R4 drained", rd_data_o, 8'h00);
  endtask

  task automatic t_fly();
    fly_evt_i = 1'b1; step(); fly_evt_i = 1'b0;
    check("R10 fly set", rd_data_o, 8'h04);
    check("R9 irq on fly", irq_o, 1);
    wr(8'h00);
    check("R10 write 0 keeps", rd_data_o, 8'h04);
    wr(8'h04);
    check("R10 write 1 clears", rd_data_o, 8'h00);
    check("R9 irq off", irq_o, 0);
  endtask

  task automatic t_overflow();
    dma_evt_i = 1'b1; step(); step(); step(); dma_evt_i = 1'b0;
    check("R5 dma pending", rd_data_o, 8'h01);
    check("R5 dma overflow", {scsi_ovf_o, dma_ovf_o}, 8'h01);
    check("R6 normal cause", abort_cause_o, 0);
    dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
    check("R4 dma gap", rd_data_o, 8'h00);
    step();
    check("R5 depth kept two", rd_data_o, 8'h01);
    dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0; step();
    check("R5 third dropped", rd_data_o, 8'h00);
    check("R5 overflow sticky", dma_ovf_o, 1);
  endtask

  task automatic t_srst();
    scsi_evt_i = 1'b1; step(); scsi_evt_i = 1'b0;
    wr(8'h10);
    check("R8 setup", rd_data_o, 8'h12);
    wr(8'h40);
    check("R8 reset bit only", rd_data_o, 8'h40);
    check("R8 pulse/ovf", {swreset_o, dma_ovf_o, irq_o}, 8'h04);
    step();
    check("R8 self clear", rd_data_o, 8'h00);
    check("R8 pulse end", swreset_o, 0);
  endtask

  task automatic t_abort();
    wr(8'h80);
    check("R6 abort bit", rd_data_o, 8'h80);
    check("R6 abort strobe", abort_req_o, 1);
    step();
    check("R6 aborted dma irq", rd_data_o, 8'h81);
    check("R6 strobe one cycle", abort_req_o, 0);
    check("R6 abort cause", abort_cause_o, 1);
    dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
    check("R7 gap after ack", rd_data_o, 8'h80);
    step();
    check("R7 repeat while set", rd_data_o, 8'h81);
    wr(8'h00);
    check("R7 abort cleared", rd_data_o, 8'h01);
    dma_ack_i = 1'b1; step(); dma_ack_i = 1'b0;
    check("R7 ack after clear", rd_data_o, 8'h00);
    step(); step();
    check("R7 no more aborted", rd_data_o, 8'h00);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_bits();
    t_scsi_stack();
    t_irq_mask();
    t_fly();
    t_overflow();
    t_srst();
    t_abort();
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule